// File: doc/BRIEF.md
# Register-Command Executor with Lagged Response Queue

This block takes 32-bit command words and executes them against a local bank of 16-bit converter registers. Each accepted command puts one 16-bit entry into a response queue, and software later drains that queue one entry at a time. The entry is not the command's own result. It is the result held over from the previous command. This models a serial link that is one command deep, so a read's value appears only after the next command has been sent.

The surrounding register bank supplies a channel-hold level taken from its master control bit 4. While that level is high, commands are thrown away. The block reports the queue's occupancy, an empty flag and a full flag. Pops are served combinationally from the queue head. All state is cleared by a synchronous active-low reset.

Top module: `adc_cmd_exec`

## Requirements
- R1: A command word carries its data in bits 15:0, its register address in bits 25:16 and its opcode in bits 29:26. Opcode 0 is no-op, 1 is read and 2 is write. Any other opcode changes no register, pushes nothing and leaves the held result as it was.
- R2: While `chan_hold` is 1, a command with `cmd_valid` high is discarded: no register write, no push, and the held result is unchanged.
- R3: A read or write whose address is NUM_REGS or above is discarded entirely. A no-op executes whatever its address field holds.
- R4: A read pushes the held result, and the addressed register's value becomes the new held result.
- R5: A write stores its data in the addressed register, pushes the held result and clears the held result to 0.
- R6: A no-op pushes the held result and clears the held result to 0.
- R7: When the queue holds DEPTH entries, a push is dropped, but the held result is still replaced as in R4 to R6.
- R8: While `pop` is high, `pop_data` shows the oldest entry and the entry is removed at the clock edge. A pop of an empty queue shows 0 and leaves the count at 0. Slots freed by pops read as 0 afterward.
- R9: After each edge, `fifo_count` equals the number of stored entries, `fifo_empty` is 1 exactly when it is 0, and `fifo_full` is 1 exactly when it equals DEPTH. Entries leave in the order they entered.
- R10: A cycle with `rst_n` low clears every register, every queue entry, the count and the held result to 0.
- R11: A pop and a push in the same cycle leave the count unchanged and keep first-in first-out order. The pop is applied first, so a full queue accepts the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_hold | input | 1 | Channel held in reset; commands are discarded |
| cmd_valid | input | 1 | A command word is written this cycle |
| cmd_word | input | 32 | Command word: opcode, address, data |
| pop | input | 1 | Remove the oldest response this cycle |
| pop_data | output | 16 | Oldest response, 0 when empty |
| fifo_count | output | $clog2(DEPTH+1) | Number of stored responses |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_full | output | 1 | Queue holds DEPTH entries |

## Verification
Several behaviours are checked by assertions on every cycle. These are the count step for each push and pop combination, including a dropped push when the queue is full. The assertions also check that every slot at or above the count reads zero, that a write lands in its register on the next cycle, and that the held result stays frozen while the channel is held and clears after a write or no-op. Other behaviours can only be shown by the bench's directed scenarios. These are the one-command lag of responses, which opcodes and addresses are rejected, FIFO ordering across a full-queue overflow, and the clearing of registers by reset. Each of them is observed through the popped values.

// File: rtl/adc_cmd_pkg.sv
// Package: shared command-word layout and opcode encodings.
// Assumes a 32-bit command word; field positions are fixed by software.
package adc_cmd_pkg;
    localparam int CMD_W   = 32;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 10;
    localparam int OP_LSB  = 26;
    localparam int ADDR_LSB = 16;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_READ  = 4'd1,
        OP_WRITE = 4'd2
    } op_e;

    typedef struct packed {
        logic [3:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_fields_t;
endpackage

// File: rtl/adc_cmd_decode.sv
// Module: splits a command word into fields and decides which action runs.
// Assumes at most one command per cycle; NUM_REGS must not exceed 1024.
module adc_cmd_decode
    import adc_cmd_pkg::*;
#(
    parameter int NUM_REGS = 128
) (
    input  logic              cmd_valid,
    input  logic              chan_hold,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              do_read,
    output logic              do_write,
    output logic              do_push,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam logic [ADDR_W:0] ADDR_LIMIT = (ADDR_W+1)'(NUM_REGS);

    cmd_fields_t f;
    logic accept, addr_ok, is_nop;

    // Field extraction and action selection
    always_comb begin
        f.op     = cmd_word[OP_LSB +: 4];
        f.addr   = cmd_word[ADDR_LSB +: ADDR_W];
        f.data   = cmd_word[DATA_W-1:0];
        accept   = cmd_valid && !chan_hold;
        addr_ok  = {1'b0, f.addr} < ADDR_LIMIT;
        is_nop   = accept && (f.op == OP_NOP);
        do_read  = accept && addr_ok && (f.op == OP_READ);
        do_write = accept && addr_ok && (f.op == OP_WRITE);
        do_push  = is_nop || do_read || do_write;
        addr     = f.addr;
        data     = f.data;
    end
endmodule

// File: rtl/adc_reg_bank.sv
// Module: array of 16-bit converter registers, one write port, one
// combinational read port. Assumes wr_idx and rd_idx are below NUM_REGS.
module adc_reg_bank #(
    parameter int NUM_REGS = 128,
    parameter int DATA_W   = 16,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    // Register storage with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // Combinational read port
    always_comb rd_data = regs[rd_idx];

    // A write is visible in its register on the next cycle
    assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/adc_resp_fifo.sv
// Module: shifting response queue. The head sits at slot 0 and every slot
// at or above the count holds zero. A pop is applied before a push in the
// same cycle. Assumes DEPTH >= 2.
module adc_resp_fifo #(
    parameter int DEPTH  = 15,
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] slot [DEPTH];
    logic              pop_do, push_do;
    logic [CNT_W-1:0]  after_pop;

    // Effective pop and push after the empty and full checks
    always_comb begin
        pop_do    = pop && (count != '0);
        after_pop = count - CNT_W'(pop_do);
        push_do   = push && (after_pop != FULL_CNT);
    end

    // Occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= after_pop + CNT_W'(push_do);
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            logic [DATA_W-1:0] above;
            if (g == DEPTH - 1) begin : g_top
                assign above = '0;
            end else begin : g_mid
                assign above = slot[g+1];
            end
            // One slot: load on push, shift down on pop
            always_ff @(posedge clk) begin
                if (!rst_n)                                    slot[g] <= '0;
                else if (push_do && after_pop == CNT_W'(g))    slot[g] <= push_data;
                else if (pop_do)                               slot[g] <= above;
            end
            // Unused slots read as zero
            assert_tail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (count <= CNT_W'(g)) |-> (slot[g] == '0));
        end
    endgenerate

    // Status outputs
    always_comb begin
        head  = slot[0];
        empty = (count == '0);
        full  = (count == FULL_CNT);
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> (count == $past(count)));
    assert_push_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (count == $past(count) + 1'b1));
    assert_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (count == '0));
    assert_both_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && push && !empty) |=> $stable(count));
    assert_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
endmodule

// File: rtl/adc_cmd_exec.sv
// Module: top of the command executor. Decodes commands, updates the
// register bank, keeps the one-deep held result and pushes it into the
// response queue. Assumes chan_hold comes from a synchronous register.
module adc_cmd_exec
    import adc_cmd_pkg::*;
#(
    parameter int NUM_REGS = 128,
    parameter int DEPTH    = 15,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_hold,
    input  logic             cmd_valid,
    input  logic [31:0]      cmd_word,
    input  logic             pop,
    output logic [15:0]      pop_data,
    output logic [CNT_W-1:0] fifo_count,
    output logic             fifo_empty,
    output logic             fifo_full
);
    logic              do_read, do_write, do_push;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data, rd_val, held_q;

    adc_cmd_decode #(.NUM_REGS(NUM_REGS)) u_decode (
        .cmd_valid(cmd_valid), .chan_hold(chan_hold), .cmd_word(cmd_word),
        .do_read(do_read), .do_write(do_write), .do_push(do_push),
        .addr(addr), .data(data)
    );

    adc_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(do_write),
        .wr_idx(addr[IDX_W-1:0]), .wr_data(data),
        .rd_idx(addr[IDX_W-1:0]), .rd_data(rd_val)
    );

    adc_resp_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(do_push), .push_data(held_q),
        .pop(pop), .head(pop_data), .count(fifo_count),
        .empty(fifo_empty), .full(fifo_full)
    );

    // Held result of the previous command
    always_ff @(posedge clk) begin
        if (!rst_n)       held_q <= '0;
        else if (do_read) held_q <= rd_val;
        else if (do_push) held_q <= '0;
    end

    assert_hold_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && chan_hold) |=> $stable(held_q));
    assert_held_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && !do_read) |=> (held_q == '0));
endmodule

// File: tb/adc_cmd_exec_bench.sv
module adc_cmd_exec_bench;
    localparam int NREG = 128;
    localparam int DEP  = 15;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        chan_hold = 0;
    logic        cmd_valid = 0;
    logic [31:0] cmd_word = '0;
    logic        pop = 0;
    logic [15:0] pop_data;
    logic [3:0]  fifo_count;
    logic        fifo_empty, fifo_full;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    adc_cmd_exec #(.NUM_REGS(NREG), .DEPTH(DEP)) u_adc_cmd_exec (
        .clk(clk), .rst_n(rst_n), .chan_hold(chan_hold), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .pop(pop), .pop_data(pop_data),
        .fifo_count(fifo_count), .fifo_empty(fifo_empty), .fifo_full(fifo_full)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int op, int addr, int data);
        return {2'b00, 4'(op), 10'(addr), 16'(data)};
    endfunction

    // One cycle: optional command and pop; checks the popped value before the edge
    task automatic step(bit v, logic [31:0] w, bit p, int exp_pop, string req);
        cmd_valid = v; cmd_word = w; pop = p;
        #1;
        if (p) check(req, pop_data, exp_pop);
        @(negedge clk);
        cmd_valid = 0; pop = 0;
    endtask

    task automatic cmd(int op, int addr, int data);
        step(1, mk(op, addr, data), 0, 0, "");
    endtask

    task automatic pop_exp(int exp, string req);
        step(0, '0, 1, exp, req);
    endtask

    task automatic check_status(int cnt, string req);
        check({req, " count"}, fifo_count, cnt);
        check({req, " empty"}, fifo_empty, cnt == 0);
        check({req, " full"},  fifo_full,  cnt == DEP);
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset_state();
        check_status(0, "R10 reset");
        check("R8 idle head", pop_data, 0);
    endtask

    task automatic t_lagged_response();
        cmd(2, 5, 16'hABCD);
        cmd(1, 5, 0);
        cmd(0, 0, 0);
        check_status(3, "R9 after three");
        pop_exp(0, "R5 write pushes held");
        pop_exp(0, "R4 read pushes held");
        pop_exp(16'hABCD, "R6 nop pushes read value");
        check_status(0, "R9 drained");
    endtask

    task automatic t_chan_hold();
        cmd(1, 5, 0);
        chan_hold = 1;
        cmd(2, 7, 16'h1111);
        cmd(0, 0, 0);
        check_status(1, "R2 no push while held");
        chan_hold = 0;
        cmd(1, 7, 0);
        cmd(0, 0, 0);
        pop_exp(0, "R4 first");
        pop_exp(16'hABCD, "R2 held result kept");
        pop_exp(0, "R2 register not written");
    endtask

    task automatic t_bad_address();
        cmd(2, 3, 16'h3333);
        cmd(5, 3, 16'h4444);
        check_status(1, "R1 unknown opcode no push");
        cmd(1, 3, 0);
        cmd(2, 200, 16'h2222);
        cmd(1, 300, 0);
        check_status(2, "R3 out-of-range discarded");
        cmd(0, 1000, 0);
        check_status(3, "R3 nop any address");
        pop_exp(0, "R5");
        pop_exp(0, "R4");
        pop_exp(16'h3333, "R1 unknown opcode left register");
    endtask

    task automatic t_overflow();
        for (int k = 0; k < 17; k++) cmd(2, k, 16'h100 + k);
        check_status(DEP, "R7 saturate");
        for (int k = 0; k < DEP; k++) pop_exp(0, "R5 write entries");
        check_status(0, "R8 drained");
        for (int k = 0; k < 17; k++) cmd(1, k, 0);
        check_status(DEP, "R7 full after reads");
        cmd(0, 0, 0);
        check_status(DEP, "R7 push dropped");
        pop_exp(0, "R9 order head");
        cmd(0, 0, 0);
        for (int k = 0; k < DEP - 2; k++) pop_exp(16'h100 + k, "R9 order");
        pop_exp(16'h10D, "R9 order last read");
        pop_exp(0, "R7 held replaced while full");
        check_status(0, "R9 empty again");
    endtask

    task automatic t_concurrent();
        cmd(1, 0, 0);
        step(1, mk(0, 0, 0), 1, 0, "R11 pop with push");
        check_status(1, "R11 count unchanged");
        pop_exp(16'h100, "R11 order kept");
        pop_exp(0, "R8 empty pop returns 0");
        check_status(0, "R8 empty pop count");
        for (int k = 0; k < DEP; k++) cmd(0, 0, 0);
        step(1, mk(1, 4, 0), 1, 0, "R11 pop while full");
        check_status(DEP, "R11 full accepts push");
        for (int k = 0; k < DEP; k++) pop_exp(0, "R11 drain");
        cmd(0, 0, 0);
        pop_exp(16'h104, "R11 pushed read result held");
    endtask

    task automatic t_reset_mid();
        cmd(2, 1, 16'h5555);
        cmd(1, 1, 0);
        check_status(2, "R10 before");
        do_reset();
        check_status(0, "R10 queue cleared");
        cmd(1, 1, 0);
        cmd(0, 0, 0);
        pop_exp(0, "R10 held cleared");
        pop_exp(0, "R10 register cleared");
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset_state();
        t_lagged_response();
        t_chan_hold();
        t_bad_address();
        t_overflow();
        t_concurrent();
        t_reset_mid();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule